// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Overlap Guard

This block is a fully associative address translation buffer. Each of its entries maps one effective page to one physical page. A 3-bit code picks the page size of each entry: the page is 1024 × 4^code bytes, from 1 KiB up to 16 MiB. Each entry also carries an 8-bit translation ID, a 6-bit permission field, a 4-bit storage-attribute field and a 2-bit flag field (little-endian and one user flag).

A lookup presents an effective address and a translation ID. One cycle later the block returns hit, the matching index, the translated physical address and the stored fields. A write port installs or invalidates one entry. An install is checked in hardware before it takes effect. It is refused when either address is not aligned to the page size, and also when its range overlaps another valid entry with the same ID. For an overlap, the index of the conflicting entry is reported. A combinational query port always shows the lowest free entry.

Top module: `vptlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, `free_idx_o` is 0 and `free_none_o` is 0.
- R2: A lookup hits only on a valid entry whose ID equals the request ID and whose effective page agrees with the request address in every bit above that entry's page offset. The result appears with `lk_done_o` high in the cycle after `lk_req_i`.
- R3: The size code c gives a page of 1024 × 4^c bytes for c = 0..7. An entry hits on the first and last byte of its page, and misses on the byte just past the page.
- R4: On a hit, `lk_pa_o` takes the real page bits above the entry's page offset and the request address bits below it.
- R5: On a hit, the stored permission field (bit 5 execute, bit 4 write, bits 3:0 zone), the attribute field (bit 3 write-through, bit 2 uncached, bit 1 coherent, bit 0 guarded) and the 2-bit flag field are returned unchanged.
- R6: An install whose effective or physical address has a nonzero bit below the page offset reports status 1 (misaligned). It leaves every entry unchanged.
- R7: An install that overlaps another valid entry with the same ID reports status 2. It gives the lowest such index on `wr_clash_idx_o` and leaves every entry unchanged. Two ranges overlap when they agree in all bits above the larger of their two page offsets. Entries with a different ID, and the entry being rewritten, never conflict.
- R8: An accepted install reports status 0, one cycle after `wr_req_i`, and the entry is live from the next cycle.
- R9: An invalidate (`wr_inval_i` high) clears the valid bit of the addressed entry and reports status 0. That entry then never hits and never conflicts.
- R10: `free_idx_o` shows the lowest entry whose valid bit is clear. When every entry is valid, `free_none_o` is 1 and `free_idx_o` is 0.
- R11: A lookup issued in the same cycle as a write sees the contents from before that write.
- R12: When an install is both misaligned and overlapping, the misaligned status 1 takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Lookup effective address |
| lk_tid_i | input | 8 | Lookup translation ID |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_index_o | output | 6 | Index of hitting entry |
| lk_pa_o | output | 32 | Translated physical address |
| lk_perm_o | output | 6 | Permission field of hit |
| lk_attr_o | output | 4 | Storage attributes of hit |
| lk_uflags_o | output | 2 | Endian/user flags of hit |
| wr_req_i | input | 1 | Write request |
| wr_inval_i | input | 1 | 1 = invalidate, 0 = install |
| wr_index_i | input | 6 | Target entry |
| wr_ea_i | input | 32 | Effective base address |
| wr_pa_i | input | 32 | Physical base address |
| wr_size_i | input | 3 | Page size code |
| wr_tid_i | input | 8 | Translation ID |
| wr_perm_i | input | 6 | Permission field |
| wr_attr_i | input | 4 | Storage attributes |
| wr_uflags_i | input | 2 | Endian/user flags |
| wr_done_o | output | 1 | Write response valid |
| wr_status_o | output | 2 | 0 accepted, 1 misaligned, 2 overlap |
| wr_clash_idx_o | output | 6 | Conflicting entry when status is 2 |
| free_idx_o | output | 6 | Lowest free entry |
| free_none_o | output | 1 | No entry free |

## Verification
A lookup and a write can land in the same cycle, including a write that installs or invalidates the very page the lookup targets. The bench issues both together, both in directed form and at random. It expects the lookup result to reflect the table from before the edge and the write response to reflect the new state. A second lookup in the following cycle then confirms that the write took effect.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_MIN = 10;
  localparam int unsigned EPN_W   = ADDR_W - OFF_MIN;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned TID_W   = 8;
  localparam int unsigned PERM_W  = 6;
  localparam int unsigned ATTR_W  = 4;
  localparam int unsigned UF_W    = 2;

  typedef enum logic [1:0] {
    WR_OK       = 2'd0,
    WR_MISALIGN = 2'd1,
    WR_OVERLAP  = 2'd2
  } wr_status_e;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [EPN_W-1:0]  rpn;
    logic [SIZE_W-1:0] size;
    logic [TID_W-1:0]  tid;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] attr;
    logic [UF_W-1:0]   uflags;
  } entry_t;

  // Page-number bits that take part in a compare for a given size code.
  function automatic logic [EPN_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
    return {EPN_W{1'b1}} << (2 * sz);
  endfunction

  // True when an address has no bit set below the page offset.
  function automatic logic offset_ok(input logic [ADDR_W-1:0] addr,
                                     input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] keep;
    keep = {ADDR_W{1'b1}} << (OFF_MIN + 2 * sz);
    return (addr & ~keep) == '0;
  endfunction

  // Physical address: real page above the offset, request bits below it.
  function automatic logic [ADDR_W-1:0] xlate(input logic [EPN_W-1:0]   rpn,
                                              input logic [ADDR_W-1:0]  ea,
                                              input logic [SIZE_W-1:0]  sz);
    logic [EPN_W-1:0] m;
    m = page_mask(sz);
    return {(rpn & m) | (ea[ADDR_W-1:OFF_MIN] & ~m), ea[OFF_MIN-1:0]};
  endfunction
endpackage

// File: rtl/vptlb_first.sv
module vptlb_first #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/vptlb_row.sv
module vptlb_row
  import vptlb_pkg::*;
#(
  parameter int unsigned SELF  = 0,
  parameter int unsigned IDX_W = 6
) (
  input  logic              valid,
  input  logic [EPN_W-1:0]  epn,
  input  logic [SIZE_W-1:0] size,
  input  logic [TID_W-1:0]  tid,
  input  logic [EPN_W-1:0]  lk_epn,
  input  logic [TID_W-1:0]  lk_tid,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic              lk_match,
  output logic              wr_clash
);
  localparam logic [IDX_W-1:0] SELF_IDX = IDX_W'(SELF);

  logic [EPN_W-1:0] own_mask;
  logic [EPN_W-1:0] both_mask;

  assign own_mask  = page_mask(size);
  assign both_mask = own_mask & page_mask(wr_size);

  assign lk_match = valid && (tid == lk_tid) &&
                    (((epn ^ lk_epn) & own_mask) == '0);
  assign wr_clash = valid && (wr_idx != SELF_IDX) && (tid == wr_tid) &&
                    (((epn ^ wr_epn) & both_mask) == '0);
endmodule

// File: rtl/vptlb.sv
module vptlb
  import vptlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req_i,
  input  logic [31:0]       lk_ea_i,
  input  logic [7:0]        lk_tid_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_index_o,
  output logic [31:0]       lk_pa_o,
  output logic [5:0]        lk_perm_o,
  output logic [3:0]        lk_attr_o,
  output logic [1:0]        lk_uflags_o,
  input  logic              wr_req_i,
  input  logic              wr_inval_i,
  input  logic [IDX_W-1:0]  wr_index_i,
  input  logic [31:0]       wr_ea_i,
  input  logic [31:0]       wr_pa_i,
  input  logic [2:0]        wr_size_i,
  input  logic [7:0]        wr_tid_i,
  input  logic [5:0]        wr_perm_i,
  input  logic [3:0]        wr_attr_i,
  input  logic [1:0]        wr_uflags_i,
  output logic              wr_done_o,
  output logic [1:0]        wr_status_o,
  output logic [IDX_W-1:0]  wr_clash_idx_o,
  output logic [IDX_W-1:0]  free_idx_o,
  output logic              free_none_o
);
  entry_t                 ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid_q;

  logic [NUM_ENTRIES-1:0] lk_match_vec;
  logic [NUM_ENTRIES-1:0] wr_clash_vec;

  // Named internal events used by the assertions.
  logic             lk_any;
  logic [IDX_W-1:0] lk_sel;
  logic             clash_any;
  logic [IDX_W-1:0] clash_sel;
  logic             free_any;
  logic             wr_misalign;
  logic             wr_reject;
  logic             install_ev;
  logic             inval_ev;
  wr_status_e       wr_status_d;

  // Per-entry compare rows.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_row
    vptlb_row #(.SELF(g), .IDX_W(IDX_W)) u_row (
      .valid    (valid_q[g]),
      .epn      (ent_q[g].epn),
      .size     (ent_q[g].size),
      .tid      (ent_q[g].tid),
      .lk_epn   (lk_ea_i[ADDR_W-1:OFF_MIN]),
      .lk_tid   (lk_tid_i),
      .wr_epn   (wr_ea_i[ADDR_W-1:OFF_MIN]),
      .wr_size  (wr_size_i),
      .wr_tid   (wr_tid_i),
      .wr_idx   (wr_index_i),
      .lk_match (lk_match_vec[g]),
      .wr_clash (wr_clash_vec[g])
    );
  end

  vptlb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .req (lk_match_vec), .idx (lk_sel), .any (lk_any)
  );
  vptlb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_clash_pick (
    .req (wr_clash_vec), .idx (clash_sel), .any (clash_any)
  );
  vptlb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free_pick (
    .req (~valid_q), .idx (free_idx_o), .any (free_any)
  );
  assign free_none_o = !free_any;

  // Write qualification.
  assign wr_misalign = !offset_ok(wr_ea_i, wr_size_i) || !offset_ok(wr_pa_i, wr_size_i);
  assign wr_reject   = wr_misalign || clash_any;
  assign install_ev  = wr_req_i && !wr_inval_i && !wr_reject;
  assign inval_ev    = wr_req_i && wr_inval_i;

  always_comb begin
    if (wr_inval_i)       wr_status_d = WR_OK;
    else if (wr_misalign) wr_status_d = WR_MISALIGN;
    else if (clash_any)   wr_status_d = WR_OVERLAP;
    else                  wr_status_d = WR_OK;
  end

  // Valid bits: the only state that reset touches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (install_ev) begin
      valid_q[wr_index_i] <= 1'b1;
    end else if (inval_ev) begin
      valid_q[wr_index_i] <= 1'b0;
    end
  end

  // Entry payload.
  always_ff @(posedge clk) begin
    if (install_ev) begin
      ent_q[wr_index_i] <= '{epn:    wr_ea_i[ADDR_W-1:OFF_MIN],
                             rpn:    wr_pa_i[ADDR_W-1:OFF_MIN],
                             size:   wr_size_i,
                             tid:    wr_tid_i,
                             perm:   wr_perm_i,
                             attr:   wr_attr_i,
                             uflags: wr_uflags_i};
    end
  end

  // Registered write response.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_done_o      <= 1'b0;
      wr_status_o    <= WR_OK;
      wr_clash_idx_o <= '0;
    end else begin
      wr_done_o <= wr_req_i;
      if (wr_req_i) begin
        wr_status_o    <= wr_status_d;
        wr_clash_idx_o <= (wr_status_d == WR_OVERLAP) ? clash_sel : '0;
      end
    end
  end

  // Registered lookup result.
  entry_t lk_ent;
  assign lk_ent = ent_q[lk_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done_o   <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_index_o  <= '0;
      lk_pa_o     <= '0;
      lk_perm_o   <= '0;
      lk_attr_o   <= '0;
      lk_uflags_o <= '0;
    end else begin
      lk_done_o <= lk_req_i;
      if (lk_req_i) begin
        lk_hit_o    <= lk_any;
        lk_index_o  <= lk_any ? lk_sel : '0;
        lk_pa_o     <= lk_any ? xlate(lk_ent.rpn, lk_ea_i, lk_ent.size) : '0;
        lk_perm_o   <= lk_any ? lk_ent.perm : '0;
        lk_attr_o   <= lk_any ? lk_ent.attr : '0;
        lk_uflags_o <= lk_any ? lk_ent.uflags : '0;
      end
    end
  end

  // Assertions.
  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> lk_done_o);

  assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !wr_inval_i && wr_reject) |=> ($stable(valid_q) && wr_status_o != WR_OK));

  assert_accept_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    install_ev |=> (valid_q[$past(wr_index_i)] && wr_status_o == WR_OK));

  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_ev |=> !valid_q[$past(wr_index_i)]);

  assert_free_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !free_none_o |-> !valid_q[free_idx_o]);

  assert_none_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    free_none_o |-> (&valid_q));
endmodule

// File: tb/vptlb_bench.sv
module vptlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        lk_req = 0;
  logic [31:0] lk_ea = 0;
  logic [7:0]  lk_tid = 0;
  logic        lk_done, lk_hit;
  logic [5:0]  lk_index;
  logic [31:0] lk_pa;
  logic [5:0]  lk_perm;
  logic [3:0]  lk_attr;
  logic [1:0]  lk_uflags;
  logic        wr_req = 0, wr_inval = 0;
  logic [5:0]  wr_index = 0;
  logic [31:0] wr_ea = 0, wr_pa = 0;
  logic [2:0]  wr_size = 0;
  logic [7:0]  wr_tid = 0;
  logic [5:0]  wr_perm = 0;
  logic [3:0]  wr_attr = 0;
  logic [1:0]  wr_uflags = 0;
  logic        wr_done;
  logic [1:0]  wr_status;
  logic [5:0]  wr_clash_idx;
  logic [5:0]  free_idx;
  logic        free_none;

  vptlb u_vptlb (
    .clk(clk), .rst_n(rst_n),
    .lk_req_i(lk_req), .lk_ea_i(lk_ea), .lk_tid_i(lk_tid),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_index_o(lk_index), .lk_pa_o(lk_pa),
    .lk_perm_o(lk_perm), .lk_attr_o(lk_attr), .lk_uflags_o(lk_uflags),
    .wr_req_i(wr_req), .wr_inval_i(wr_inval), .wr_index_i(wr_index),
    .wr_ea_i(wr_ea), .wr_pa_i(wr_pa), .wr_size_i(wr_size), .wr_tid_i(wr_tid),
    .wr_perm_i(wr_perm), .wr_attr_i(wr_attr), .wr_uflags_i(wr_uflags),
    .wr_done_o(wr_done), .wr_status_o(wr_status), .wr_clash_idx_o(wr_clash_idx),
    .free_idx_o(free_idx), .free_none_o(free_none)
  );

  int tests = 0;
  int fails = 0;

  // Reference model.
  bit          mv    [N];
  logic [31:0] mea   [N];
  logic [31:0] mpa   [N];
  int          msz   [N];
  logic [7:0]  mtid  [N];
  logic [5:0]  mperm [N];
  logic [3:0]  mattr [N];
  logic [1:0]  muf   [N];

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int offbits(input int sz);
    return 10 + 2 * sz;
  endfunction

  function automatic int m_lookup(input logic [31:0] ea, input logic [7:0] tid);
    for (int i = 0; i < N; i++) begin
      if (mv[i] && mtid[i] == tid && (ea >> offbits(msz[i])) == (mea[i] >> offbits(msz[i])))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] m_pa(input int e, input logic [31:0] ea);
    logic [31:0] lo;
    lo = (32'h1 << offbits(msz[e])) - 1;
    return (mpa[e] & ~lo) | (ea & lo);
  endfunction

  function automatic int m_eval(input bit inval, input int idx, input logic [31:0] ea,
                                input logic [31:0] pa, input int sz, input logic [7:0] tid,
                                output int cidx);
    logic [31:0] lo;
    cidx = 0;
    if (inval) return 0;
    lo = (32'h1 << offbits(sz)) - 1;
    if ((ea & lo) != 0 || (pa & lo) != 0) return 1;
    for (int i = 0; i < N; i++) begin
      if (i != idx && mv[i] && mtid[i] == tid) begin
        int s2;
        s2 = offbits(sz > msz[i] ? sz : msz[i]);
        if ((ea >> s2) == (mea[i] >> s2)) begin
          cidx = i;
          return 2;
        end
      end
    end
    return 0;
  endfunction

  task automatic check_lk(input int e, input logic [31:0] ea, input string rq);
    chk(rq, "lk_done", lk_done, 1);
    chk(rq, "lk_hit", lk_hit, e >= 0);
    if (e >= 0) begin
      chk(rq, "lk_index", lk_index, e);
      chk(rq, "lk_pa", lk_pa, m_pa(e, ea));
      chk(rq, "lk_perm", lk_perm, mperm[e]);
      chk(rq, "lk_attr", lk_attr, mattr[e]);
      chk(rq, "lk_uflags", lk_uflags, muf[e]);
    end
  endtask

  task automatic check_free(input string rq);
    int f;
    f = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) f = i;
    chk(rq, "free_none", free_none, f < 0);
    chk(rq, "free_idx", free_idx, f < 0 ? 0 : f);
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [7:0] tid, input string rq);
    int e;
    e = m_lookup(ea, tid);
    @(negedge clk);
    lk_req = 1; lk_ea = ea; lk_tid = tid;
    @(posedge clk); #1;
    lk_req = 0;
    check_lk(e, ea, rq);
  endtask

  // Write, optionally with a lookup in the same cycle.
  task automatic write_op(input bit inval, input int idx, input logic [31:0] ea,
                          input logic [31:0] pa, input int sz, input logic [7:0] tid,
                          input logic [5:0] perm, input logic [3:0] attr,
                          input logic [1:0] uf, input int exp_st, input string rq,
                          input bit with_lk, input logic [31:0] lea, input logic [7:0] ltid);
    int st, cidx, le;
    st = m_eval(inval, idx, ea, pa, sz, tid, cidx);
    le = m_lookup(lea, ltid);
    if (exp_st >= 0) chk(rq, "model status", st, exp_st);
    @(negedge clk);
    wr_req = 1; wr_inval = inval; wr_index = idx[5:0]; wr_ea = ea; wr_pa = pa;
    wr_size = sz[2:0]; wr_tid = tid; wr_perm = perm; wr_attr = attr; wr_uflags = uf;
    lk_req = with_lk; lk_ea = lea; lk_tid = ltid;
    @(posedge clk); #1;
    wr_req = 0; lk_req = 0;
    chk(rq, "wr_done", wr_done, 1);
    chk(rq, "wr_status", wr_status, st);
    if (st == 2) chk(rq, "wr_clash_idx", wr_clash_idx, cidx);
    if (with_lk) check_lk(le, lea, {rq, " same-cycle lookup"});
    if (inval) mv[idx] = 0;
    else if (st == 0) begin
      mv[idx] = 1; mea[idx] = ea; mpa[idx] = pa; msz[idx] = sz; mtid[idx] = tid;
      mperm[idx] = perm; mattr[idx] = attr; muf[idx] = uf;
    end
    check_free(rq);
  endtask

  task automatic install(input int idx, input logic [31:0] ea, input logic [31:0] pa,
                         input int sz, input logic [7:0] tid, input int exp_st, input string rq);
    write_op(0, idx, ea, pa, sz, tid, 6'(idx + 7), 4'(idx + 3), 2'(idx), exp_st, rq, 0, 0, 0);
  endtask

  task automatic inval(input int idx, input string rq);
    write_op(1, idx, 0, 0, 0, 0, 0, 0, 0, 0, rq, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    check_free("R1");
    lookup(32'h0001_0000, 8'd5, "R1");

    // R2 R4 R5: basic 4K mapping
    install(0, 32'h0001_0000, 32'h8002_0000, 1, 8'd5, 0, "R8");
    lookup(32'h0001_0ABC, 8'd5, "R2 R4 R5");
    lookup(32'h0001_0ABC, 8'd6, "R2 tid mismatch");
    lookup(32'h0001_1000, 8'd5, "R2 next page");

    // R11: same-cycle lookup and install of the looked-up page
    write_op(0, 1, 32'h0010_0000, 32'h0030_0400, 0, 8'd5, 6'h21, 4'h9, 2'b10, 0, "R11",
             1, 32'h0010_0123, 8'd5);
    lookup(32'h0010_0123, 8'd5, "R11 after write");
    // R11: same-cycle invalidate still sees old entry
    write_op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R11 inval", 1, 32'h0010_0123, 8'd5);
    lookup(32'h0010_0123, 8'd5, "R11 R9 after inval");

    // R6: misaligned effective and physical addresses
    install(2, 32'h0001_2000, 32'h0004_0000, 2, 8'd5, 1, "R6 ea");
    install(2, 32'h0004_0000, 32'h0001_2000, 2, 8'd5, 1, "R6 pa");
    lookup(32'h0004_0010, 8'd5, "R6 unchanged");

    // R7: overlap with entry 0 (256K range covers 0x10000)
    install(5, 32'h0000_0000, 32'h0000_0000, 4, 8'd5, 2, "R7 overlap");
    install(5, 32'h0000_0000, 32'h0000_0000, 4, 8'd7, 0, "R7 other tid");
    install(0, 32'h0001_0000, 32'h9000_0000, 1, 8'd5, 0, "R7 self rewrite");
    lookup(32'h0001_0004, 8'd5, "R7 rewritten");
    // R12: misaligned and overlapping
    install(6, 32'h0001_0400, 32'h0000_0000, 1, 8'd5, 1, "R12");

    // R9: invalidate then previous conflict disappears
    inval(0, "R9");
    lookup(32'h0001_0004, 8'd5, "R9 no hit");
    install(6, 32'h0000_0000, 32'h0000_0000, 4, 8'd5, 0, "R9 no conflict");

    // R3: each size code, first/last byte hit, next byte miss
    for (int c = 0; c < 8; c++) begin
      logic [31:0] base, sz;
      base = 32'(c + 1) << 24;
      sz = 32'h400 << (2 * c);
      install(10 + c, base, 32'(8'h80 + c) << 24, c, 8'(20 + c), 0, "R3 install");
      lookup(base, 8'(20 + c), "R3 first");
      lookup(base + sz - 1, 8'(20 + c), "R3 last");
      lookup(base + sz, 8'(20 + c), "R3 past");
    end

    // R10: fill all entries
    for (int i = 0; i < N; i++) begin
      if (!mv[i]) install(i, 32'hF000_0000 + (32'(i) << 12), 32'(i) << 12, 1, 8'd200, 0, "R10 fill");
    end
    check_free("R10 full");
    inval(37, "R10 one free");
    inval(12, "R10 lower free");

    // Random mix
    for (int n = 0; n < 2500; n++) begin
      int r, idx, sz, j;
      logic [31:0] ea, pa, lo;
      logic [7:0] tid;
      r = $urandom % 4;
      idx = $urandom % N;
      sz = $urandom % 8;
      lo = (32'h1 << offbits(sz)) - 1;
      ea = ($urandom & 32'h0FFF_FFFF) & ~lo;
      pa = $urandom & ~lo;
      if (sz > 0 && $urandom % 6 == 0) ea = ea | 32'h400;
      tid = 8'(1 + $urandom % 3);
      j = $urandom % N;
      if (r == 0) begin
        if (mv[j]) begin
          logic [31:0] q;
          q = mea[j] | ($urandom & ((32'h1 << offbits(msz[j])) - 1));
          if ($urandom % 4 == 0) q = q ^ (32'h1 << offbits(msz[j]));
          lookup(q, mtid[j], "R2 R4 R5 random");
        end else lookup(ea, tid, "R2 random");
      end else if (r == 3) begin
        logic [31:0] q;
        q = mv[j] ? (mea[j] | 32'h3) : ea;
        write_op($urandom % 4 == 0, idx, ea, pa, sz, tid, 6'($urandom), 4'($urandom),
                 2'($urandom), -1, "R11 random", 1, q, mv[j] ? mtid[j] : tid);
      end else begin
        write_op($urandom % 5 == 0, idx, ea, pa, sz, tid, 6'($urandom), 4'($urandom),
                 2'($urandom), -1, "R6 R7 R8 R9 random", 0, 0, 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule